// File: doc/BRIEF.md
# Debug Scan-Chain Register Access Router

This block sits between a debug port's command stream and the targets that a debugger can reach. Each request is one of three operations: read, write or chain select. A chain select picks the target for later reads and writes. There are four targets: the processor's special registers, a trace chain, a local bank of development-interface registers, and the system memory bus. Every request returns a response that carries read data and a two-bit error code.

The development-interface bank sits inside the block. It holds the mode, trigger-select, qualifier-select and stop-select registers, a RISC-control register, a row of watchpoint-record registers and one breakpoint-record register. The RISC-control register drives the processor's stall and reset. The reset hold is kept for as long as its reset bit is set. A system reset pulse is issued only when that bit is cleared.

The processor register file and the memory-bus slave sit outside the block and are reached through ports. Only one request is in flight at a time. Processor-register and memory accesses hold off new requests until they complete.

Top module: `dbg_access_router`

## Requirements
- R1: After reset, `req_ready` is 1. `rsp_valid`, `cpu_stall`, `cpu_reset`, `sys_rst_pulse`, `mem_req` and `spr_req` are 0, `wp_eval_en` is 1, and the selected chain is the processor-register chain.
- R2: A chain-select request (`req_op` = 2 or 3) takes its chain ID from `req_addr`. The valid IDs are 0 for processor registers, 1 for trace, 2 for the development bank and 3 for memory. Any other ID returns error 1 (invalid chain) and keeps the previous chain. A valid ID returns error 0.
- R3: On the trace chain, a read (`req_op` = 0) returns data 0 with error 0. A write (`req_op` = 1) returns error 3 (access exception).
- R4: In the development bank, addresses 0 to 3 are plain registers. Address 4 is RISC-control. Addresses 5 to 4+NUM_WP are watchpoint records and 5+NUM_WP is the breakpoint record. A read returns the last value written. Any other address returns error 2 with read data 0 and leaves every register unchanged.
- R5: RISC-control bit 0 holds `cpu_reset` high and `wp_eval_en` low while it is set. Clearing it from 1 to 0 gives a `sys_rst_pulse` exactly one cycle long, visible in the cycle after the write is accepted. Rewriting the bit with the same value gives no pulse.
- R6: RISC-control bit 1 drives `cpu_stall`. While `dbg_disable` is high, `cpu_stall` is 0 from the next clock edge on. RISC-control keeps only bits 1:0, and the other bits read back as 0.
- R7: On the memory chain, an address between MEM_BASE and MEM_LIMIT inclusive raises `mem_req` with the address, write flag and data. `mem_req` stays high and the address stays stable until `mem_ack`. The response follows on the acknowledge edge, with `mem_rdata` as the data for a read. An address outside that range returns error 2 and never raises `mem_req`.
- R8: On the processor-register chain, an accepted request gives a one-cycle `spr_req` with `spr_addr`, `spr_we` and `spr_wdata`. `spr_rdata` is captured on the next edge as the read data, with error 0.
- R9: While a processor-register or memory access is in progress, `req_ready` is 0.
- R10: Debug reset (`rst`) clears RISC-control, `cpu_stall` and `cpu_reset` without producing `sys_rst_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high debug-logic reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 chain select |
| req_addr | input | ADDR_W | Register/memory address, or chain ID for a chain select |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |
| rsp_err | output | 2 | 0 ok, 1 invalid chain, 2 invalid address, 3 access exception |
| spr_req | output | 1 | Processor-register access strobe |
| spr_we | output | 1 | Processor-register write flag |
| spr_addr | output | ADDR_W | Processor-register address |
| spr_wdata | output | DATA_W | Processor-register write data |
| spr_rdata | input | DATA_W | Processor-register read data |
| mem_req | output | 1 | Memory-bus request, held until acknowledge |
| mem_we | output | 1 | Memory-bus write flag |
| mem_addr | output | ADDR_W | Memory-bus address |
| mem_wdata | output | DATA_W | Memory-bus write data |
| mem_rdata | input | DATA_W | Memory-bus read data |
| mem_ack | input | 1 | Memory-bus acknowledge |
| dbg_disable | input | 1 | Debugger-disable bit; masks the stall |
| cpu_stall | output | 1 | Processor stall |
| cpu_reset | output | 1 | Processor reset hold |
| wp_eval_en | output | 1 | Watchpoint evaluation enable |
| sys_rst_pulse | output | 1 | One-cycle full system reset |

## Verification
The bench builds the block with ADDR_W = 16 and a memory window of 0x0100 to 0x01FF. This puts both window edges, and the addresses just outside them, within a few directed requests. NUM_WP stays at 11, so the bank spans addresses 0 to 16. The bench covers the first and last watchpoint record, the breakpoint record and the first invalid address 17. The memory responder acknowledges two cycles late, which shows that the request is held and `req_ready` is blocked.

// File: rtl/dbg_router_pkg.sv
package dbg_router_pkg;
  typedef enum logic [1:0] {
    CH_PROC  = 2'd0,
    CH_TRACE = 2'd1,
    CH_DEV   = 2'd2,
    CH_MEM   = 2'd3
  } chain_e;

  localparam logic [1:0] ERR_OK       = 2'd0;
  localparam logic [1:0] ERR_CHAIN    = 2'd1;
  localparam logic [1:0] ERR_ADDR     = 2'd2;
  localparam logic [1:0] ERR_ACCESS   = 2'd3;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;

  localparam int RCTL_RESET_BIT = 0;
  localparam int RCTL_STALL_BIT = 1;
  localparam int RCTL_INDEX     = 4;
  localparam int NUM_CHAINS     = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SPR  = 2'd1,
    ST_MEM  = 2'd2
  } state_e;
endpackage

// File: rtl/dbg_mem_window.sv
module dbg_mem_window #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] MEM_LIMIT = 32'h0001_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range
);
  logic above_base;
  logic below_limit;

  always_comb begin
    above_base  = (addr >= MEM_BASE);
    below_limit = (addr <= MEM_LIMIT);
    in_range    = above_base && below_limit;
  end
endmodule

// File: rtl/dbg_devint_bank.sv
module dbg_devint_bank
  import dbg_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NUM_WP = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dbg_disable,
  output logic [DATA_W-1:0] rd_data,
  output logic              addr_ok,
  output logic              cpu_stall,
  output logic              cpu_reset,
  output logic              wp_eval_en,
  output logic              sys_rst_pulse
);
  localparam int NUM_REGS = RCTL_INDEX + 1 + NUM_WP + 1;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs_q [0:NUM_REGS-1];
  logic [1:0]        rctl_q;
  logic [1:0]        rctl_d;
  logic [IDX_W-1:0]  idx;
  logic              is_rctl;
  logic              stall_q;
  logic              pulse_q;

  always_comb begin
    addr_ok = (addr < ADDR_W'(NUM_REGS));
    idx     = addr[IDX_W-1:0];
    is_rctl = addr_ok && (idx == IDX_W'(RCTL_INDEX));
    rctl_d  = (wr_en && is_rctl) ? wdata[1:0] : rctl_q;
    if (!addr_ok)
      rd_data = '0;
    else if (is_rctl)
      rd_data = DATA_W'(rctl_q);
    else
      rd_data = regs_q[idx];
  end

  // General registers: no reset, so the array maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en && addr_ok && !is_rctl)
      regs_q[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rctl_q  <= '0;
      stall_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      rctl_q  <= rctl_d;
      stall_q <= rctl_d[RCTL_STALL_BIT] & ~dbg_disable;
      pulse_q <= rctl_q[RCTL_RESET_BIT] & ~rctl_d[RCTL_RESET_BIT];
    end
  end

  assign cpu_stall     = stall_q;
  assign cpu_reset     = rctl_q[RCTL_RESET_BIT];
  assign wp_eval_en    = ~rctl_q[RCTL_RESET_BIT];
  assign sys_rst_pulse = pulse_q;

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
    sys_rst_pulse |=> !sys_rst_pulse);
  a_r5_pulse_after_hold: assert property (@(posedge clk) disable iff (rst)
    sys_rst_pulse |-> ($past(cpu_reset) && !cpu_reset));
  a_r6_disable_masks: assert property (@(posedge clk) disable iff (rst)
    $past(dbg_disable) |-> !cpu_stall);
endmodule

// File: rtl/dbg_access_router.sv
module dbg_access_router
  import dbg_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NUM_WP = 11,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] MEM_LIMIT = 32'h0001_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_err,
  output logic              spr_req,
  output logic              spr_we,
  output logic [ADDR_W-1:0] spr_addr,
  output logic [DATA_W-1:0] spr_wdata,
  input  logic [DATA_W-1:0] spr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              dbg_disable,
  output logic              cpu_stall,
  output logic              cpu_reset,
  output logic              wp_eval_en,
  output logic              sys_rst_pulse
);
  state_e            state_q;
  chain_e            chain_q;
  logic              accept;
  logic              is_sel;
  logic              is_wr;
  logic              chain_ok;
  logic              win_ok;
  logic              dev_wr;
  logic              dev_ok;
  logic [DATA_W-1:0] dev_rdata;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_valid && req_ready;
    is_sel    = req_op[1];
    is_wr     = (req_op == OP_WRITE);
    chain_ok  = (req_addr < ADDR_W'(NUM_CHAINS));
    dev_wr    = accept && is_wr && (chain_q == CH_DEV);
  end

  dbg_mem_window #(
    .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .MEM_LIMIT(MEM_LIMIT)
  ) i_window (
    .addr(req_addr), .in_range(win_ok)
  );

  dbg_devint_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WP(NUM_WP)
  ) i_bank (
    .clk(clk), .rst(rst), .wr_en(dev_wr), .addr(req_addr), .wdata(req_wdata),
    .dbg_disable(dbg_disable), .rd_data(dev_rdata), .addr_ok(dev_ok),
    .cpu_stall(cpu_stall), .cpu_reset(cpu_reset), .wp_eval_en(wp_eval_en),
    .sys_rst_pulse(sys_rst_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      chain_q   <= CH_PROC;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= ERR_OK;
      spr_req   <= 1'b0;
      spr_we    <= 1'b0;
      spr_addr  <= '0;
      spr_wdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      spr_req   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (is_sel) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
              if (chain_ok) begin
                chain_q <= chain_e'(req_addr[1:0]);
                rsp_err <= ERR_OK;
              end else begin
                rsp_err <= ERR_CHAIN;
              end
            end else begin
              unique case (chain_q)
                CH_PROC: begin
                  spr_req   <= 1'b1;
                  spr_we    <= is_wr;
                  spr_addr  <= req_addr;
                  spr_wdata <= req_wdata;
                  state_q   <= ST_SPR;
                end
                CH_TRACE: begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= '0;
                  rsp_err   <= is_wr ? ERR_ACCESS : ERR_OK;
                end
                CH_DEV: begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= (!is_wr && dev_ok) ? dev_rdata : '0;
                  rsp_err   <= dev_ok ? ERR_OK : ERR_ADDR;
                end
                CH_MEM: begin
                  if (win_ok) begin
                    mem_req   <= 1'b1;
                    mem_we    <= is_wr;
                    mem_addr  <= req_addr;
                    mem_wdata <= req_wdata;
                    state_q   <= ST_MEM;
                  end else begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= '0;
                    rsp_err   <= ERR_ADDR;
                  end
                end
                default: ;
              endcase
            end
          end
        end
        ST_SPR: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= spr_we ? '0 : spr_rdata;
          rsp_err   <= ERR_OK;
          state_q   <= ST_IDLE;
        end
        ST_MEM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_we ? '0 : mem_rdata;
            rsp_err   <= ERR_OK;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    (mem_req || spr_req) |-> !req_ready);
  a_r7_in_window: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_addr >= MEM_BASE) && (mem_addr <= MEM_LIMIT)));
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r8_spr_pulse: assert property (@(posedge clk) disable iff (rst)
    spr_req |=> (!spr_req && rsp_valid));
endmodule

// File: tb/test_dbg_access_router.sv
module test_dbg_access_router;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [1:0]    rsp_err;
  logic          spr_req, spr_we;
  logic [AW-1:0] spr_addr;
  logic [DW-1:0] spr_wdata;
  logic [DW-1:0] spr_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic          dbg_disable = 1'b0;
  logic          cpu_stall, cpu_reset, wp_eval_en, sys_rst_pulse;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic          snap_ready, snap_spr_req, snap_spr_we, snap_mem_req;
  logic [DW-1:0] snap_spr_wdata;
  logic          last_mem_we;
  logic [AW-1:0] last_mem_addr;
  logic [DW-1:0] last_mem_wdata;
  logic [DW-1:0] rd;
  logic [1:0]    er;

  dbg_access_router #(
    .DATA_W(DW), .ADDR_W(AW), .NUM_WP(11),
    .MEM_BASE(16'h0100), .MEM_LIMIT(16'h01FF)
  ) i_dbg_access_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .spr_req(spr_req), .spr_we(spr_we), .spr_addr(spr_addr),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dbg_disable(dbg_disable), .cpu_stall(cpu_stall), .cpu_reset(cpu_reset),
    .wp_eval_en(wp_eval_en), .sys_rst_pulse(sys_rst_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // processor register file model
  assign spr_rdata = {16'hC0DE, spr_addr};

  // memory slave: acknowledge on the second falling edge of a request
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        cnt++;
        if (cnt == 2) begin
          mem_ack        = 1'b1;
          mem_rdata      = {16'hBEEF, mem_addr};
          last_mem_we    = mem_we;
          last_mem_addr  = mem_addr;
          last_mem_wdata = mem_wdata;
        end
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rdata, output logic [1:0] err);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid      = 1'b0;
    snap_ready     = req_ready;
    snap_spr_req   = spr_req;
    snap_spr_we    = spr_we;
    snap_spr_wdata = spr_wdata;
    snap_mem_req   = mem_req;
    while (!rsp_valid) @(negedge clk);
    rdata = rsp_rdata;
    err   = rsp_err;
  endtask

  task automatic t_reset();
    check("R1 ready", DW'(req_ready), 1);
    check("R1 rsp_valid", DW'(rsp_valid), 0);
    check("R1 stall", DW'(cpu_stall), 0);
    check("R1 cpu_reset", DW'(cpu_reset), 0);
    check("R1 pulse", DW'(sys_rst_pulse), 0);
    check("R1 wp_eval_en", DW'(wp_eval_en), 1);
    check("R1 mem_req", DW'(mem_req), 0);
    check("R1 spr_req", DW'(spr_req), 0);
  endtask

  task automatic t_spr();
    do_req(2'd0, 16'h0042, 0, rd, er);
    check("R1 R8 default chain strobe", DW'(snap_spr_req), 1);
    check("R9 busy during spr", DW'(snap_ready), 0);
    check("R8 read data", rd, 32'hC0DE0042);
    check("R8 read err", DW'(er), 0);
    do_req(2'd1, 16'h0010, 32'h0000_5555, rd, er);
    check("R8 write flag", DW'(snap_spr_we), 1);
    check("R8 write data", snap_spr_wdata, 32'h0000_5555);
    check("R8 write err", DW'(er), 0);
  endtask

  task automatic t_chain();
    do_req(2'd2, 16'd5, 0, rd, er);
    check("R2 bad id 5", DW'(er), 1);
    do_req(2'd2, 16'd1, 0, rd, er);
    check("R2 trace id", DW'(er), 0);
    do_req(2'd3, 16'd9, 0, rd, er);
    check("R2 bad id 9", DW'(er), 1);
    do_req(2'd1, 16'h0, 32'h1, rd, er);
    check("R2 chain kept after bad id", DW'(er), 3);
  endtask

  task automatic t_trace();
    do_req(2'd0, 16'h0033, 0, rd, er);
    check("R3 trace read data", rd, 0);
    check("R3 trace read err", DW'(er), 0);
    do_req(2'd1, 16'h0033, 32'hFFFF, rd, er);
    check("R3 trace write err", DW'(er), 3);
  endtask

  task automatic t_devint();
    do_req(2'd2, 16'd2, 0, rd, er);
    check("R2 dev id", DW'(er), 0);
    do_req(2'd1, 16'd0, 32'hA1A1_0001, rd, er);
    do_req(2'd1, 16'd3, 32'h3333_0003, rd, er);
    do_req(2'd1, 16'd5, 32'h5555_0005, rd, er);
    do_req(2'd1, 16'd15, 32'hF0F0_000F, rd, er);
    do_req(2'd1, 16'd16, 32'h1616_0010, rd, er);
    check("R4 write err", DW'(er), 0);
    do_req(2'd0, 16'd0, 0, rd, er);
    check("R4 mode readback", rd, 32'hA1A1_0001);
    do_req(2'd0, 16'd3, 0, rd, er);
    check("R4 stop-select readback", rd, 32'h3333_0003);
    do_req(2'd0, 16'd5, 0, rd, er);
    check("R4 first watch record", rd, 32'h5555_0005);
    do_req(2'd0, 16'd15, 0, rd, er);
    check("R4 last watch record", rd, 32'hF0F0_000F);
    do_req(2'd1, 16'd17, 32'hDEAD_0011, rd, er);
    check("R4 bad write err", DW'(er), 2);
    do_req(2'd0, 16'd17, 0, rd, er);
    check("R4 bad read err", DW'(er), 2);
    check("R4 bad read data", rd, 0);
    do_req(2'd0, 16'd16, 0, rd, er);
    check("R4 breakpoint record untouched", rd, 32'h1616_0010);
    do_req(2'd0, 16'h0100, 0, rd, er);
    check("R4 far address err", DW'(er), 2);
  endtask

  task automatic t_rctl_reset();
    do_req(2'd1, 16'd4, 32'h1, rd, er);
    check("R5 hold reset", DW'(cpu_reset), 1);
    check("R5 watch eval off", DW'(wp_eval_en), 0);
    check("R5 no pulse on set", DW'(sys_rst_pulse), 0);
    do_req(2'd1, 16'd4, 32'h1, rd, er);
    check("R5 no pulse on rewrite", DW'(sys_rst_pulse), 0);
    do_req(2'd1, 16'd4, 32'h0, rd, er);
    check("R5 pulse on clear", DW'(sys_rst_pulse), 1);
    check("R5 hold released", DW'(cpu_reset), 0);
    @(negedge clk);
    check("R5 pulse one cycle", DW'(sys_rst_pulse), 0);
    check("R5 watch eval on", DW'(wp_eval_en), 1);
  endtask

  task automatic t_stall();
    do_req(2'd1, 16'd4, 32'hFFFF_FFF2, rd, er);
    check("R6 stall set", DW'(cpu_stall), 1);
    check("R6 no reset from stall write", DW'(cpu_reset), 0);
    do_req(2'd0, 16'd4, 0, rd, er);
    check("R6 control readback", rd, 32'h2);
    dbg_disable = 1'b1;
    @(negedge clk);
    check("R6 masked by disable", DW'(cpu_stall), 0);
    dbg_disable = 1'b0;
    @(negedge clk);
    check("R6 stall returns", DW'(cpu_stall), 1);
    do_req(2'd1, 16'd4, 32'h0, rd, er);
    check("R6 stall cleared", DW'(cpu_stall), 0);
  endtask

  task automatic t_mem();
    do_req(2'd2, 16'd3, 0, rd, er);
    do_req(2'd0, 16'h0123, 0, rd, er);
    check("R7 request raised", DW'(snap_mem_req), 1);
    check("R9 busy during mem", DW'(snap_ready), 0);
    check("R7 read data", rd, 32'hBEEF0123);
    check("R7 read err", DW'(er), 0);
    do_req(2'd1, 16'h01FF, 32'hDEAD_BEEF, rd, er);
    check("R7 upper edge err", DW'(er), 0);
    check("R7 write flag", DW'(last_mem_we), 1);
    check("R7 write addr", DW'(last_mem_addr), 32'h01FF);
    check("R7 write data", last_mem_wdata, 32'hDEAD_BEEF);
    do_req(2'd0, 16'h0100, 0, rd, er);
    check("R7 lower edge data", rd, 32'hBEEF0100);
    do_req(2'd0, 16'h0200, 0, rd, er);
    check("R7 above window err", DW'(er), 2);
    check("R7 no request above", DW'(snap_mem_req), 0);
    do_req(2'd1, 16'h00FF, 32'h1, rd, er);
    check("R7 below window err", DW'(er), 2);
    check("R7 no request below", DW'(snap_mem_req), 0);
  endtask

  task automatic t_dbg_reset();
    do_req(2'd2, 16'd2, 0, rd, er);
    do_req(2'd1, 16'd4, 32'h3, rd, er);
    check("R10 pre stall", DW'(cpu_stall), 1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 stall cleared", DW'(cpu_stall), 0);
    check("R10 reset hold cleared", DW'(cpu_reset), 0);
    check("R10 no pulse", DW'(sys_rst_pulse), 0);
    @(negedge clk);
    check("R10 no pulse after", DW'(sys_rst_pulse), 0);
    do_req(2'd2, 16'd2, 0, rd, er);
    do_req(2'd0, 16'd4, 0, rd, er);
    check("R10 control cleared", rd, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG_CYCLES) begin
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_spr();
    t_chain();
    t_trace();
    t_devint();
    t_rctl_reset();
    t_stall();
    t_mem();
    t_dbg_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule